// File: doc/BRIEF.md
# Per-Core Inter-Processor Interrupt Register File

This block holds the inter-processor interrupt state of a single core. A local register bus reaches a 32-bit pending-status register, a 32-bit enable register, a write-only set port, a write-only clear port and a 32-byte mailbox window made of four 64-bit buffers. The window takes byte-addressed accesses of 1, 2, 4 or 8 bytes. A single level interrupt line tells the core that at least one status bit is pending.

A second, remote port lets another core's sender act on this register file without going through the bus. It can OR a vector into the pending status, and it can overwrite one 32-bit word of the mailbox window. Both remote actions take effect in the cycle they are presented. They merge with whatever the bus access does in the same cycle.

The bus side is controlled by a two-state machine. In `ST_IDLE` the block accepts a request when `req_valid` and `req_ready` are both high, and on that edge it moves to `ST_RESP`. In `ST_RESP` it presents the response for exactly one cycle and then always returns to `ST_IDLE`. Register effects and read data are taken at the accepting edge.

Top module: `ipi_regfile`

## Requirements
- R1: After reset, status, enable and all mailbox bytes read as zero, `irq` is low, `req_ready` is high and `rsp_valid` is low.
- R2: A write to offset 0x008 (set port) ORs `req_wdata[31:0]` into status. `irq` rises when status was zero before the write and the data is non-zero. Writing zero data leaves `irq` low.
- R3: A write to offset 0x00C (clear port) clears in status every bit that is one in `req_wdata[31:0]`. `irq` falls only when the resulting status is zero, and otherwise stays high.
- R4: Reads of the set and clear ports return zero without error. A write to offset 0x000 (status) gets `rsp_err` high and leaves status unchanged. A read of offset 0x000 returns status zero-extended.
- R5: Offset 0x004 (enable) stores `req_wdata[31:0]` and reads back that value zero-extended. It has no effect on `irq`.
- R6: Offsets 0x020 to 0x03F form a little-endian byte window. A 1-, 2-, 4- or 8-byte access at offset o reads or writes the bytes o-0x20 upward, and a read returns them zero-extended in `rsp_rdata`.
- R7: A window access whose offset plus length exceeds 0x40, or any access to an offset that is not listed in R2 to R6, gets `rsp_err` high, returns zero data and changes nothing.
- R8: A window access whose length is not 1, 2, 4 or 8 (and that stays inside the window) returns zero on read, changes nothing on write, and gets no error.
- R9: When the length is 1, 2, 4 or 8 and the offset is not a multiple of it, `rsp_misalign` is high in the response, and the access still completes as in R6.
- R10: `rmt_set_valid` ORs `rmt_set_vec` into status in that cycle. It merges with a bus set in the same cycle. With a bus clear in the same cycle, the clear applies first and the remote vector is ORed in after. `irq` follows the rules of R2 and R3.
- R11: `rmt_mail_valid` writes `rmt_mail_data` to window bytes 4k to 4k+3, where k is `rmt_mail_idx`, little-endian. Where a bus write in the same cycle touches the same bytes, the remote data wins.
- R12: An accepted request gives `rsp_valid` high for exactly the next cycle, with `req_ready` low during that cycle. Only `req_addr[8:0]` selects the register, and higher address bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Access address; low 9 bits are the offset |
| req_len | input | 4 | Access length in bytes |
| req_wdata | input | 64 | Write data, byte 0 in bits 7:0 |
| rsp_valid | output | 1 | Response present |
| rsp_rdata | output | 64 | Read data, zero for writes and errors |
| rsp_err | output | 1 | Access rejected |
| rsp_misalign | output | 1 | Offset not aligned to length |
| rmt_set_valid | input | 1 | Remote status set strobe |
| rmt_set_vec | input | 32 | Bits to OR into status |
| rmt_mail_valid | input | 1 | Remote mailbox word write strobe |
| rmt_mail_idx | input | 3 | 32-bit word index within the window |
| rmt_mail_data | input | 32 | Remote mailbox word |
| irq | output | 1 | Level interrupt to the core |

## Verification
A corrupted status register shows up on the very next clock in two ways: `irq` disagrees with whether any bit is pending, and the next read of offset 0x000 returns the wrong value. The bench compares `irq` against its model on every cycle. A wrong mailbox byte stays hidden until a read covers it. For this reason each window write is followed by reads of mixed sizes and offsets that span the written bytes and their neighbours. A stuck bus state shows up within one cycle as `req_ready` or `rsp_valid` holding at the wrong level.

// File: rtl/ipi_regfile_pkg.sv
package ipi_regfile_pkg;
    localparam int DATA_W   = 64;
    localparam int STATUS_W = 32;
    localparam int LEN_W    = 4;
    localparam int OFF_W    = 9;

    localparam logic [OFF_W-1:0] OFF_STATUS = 9'h000;
    localparam logic [OFF_W-1:0] OFF_ENABLE = 9'h004;
    localparam logic [OFF_W-1:0] OFF_SET    = 9'h008;
    localparam logic [OFF_W-1:0] OFF_CLEAR  = 9'h00C;
    localparam logic [OFF_W-1:0] OFF_MBOX   = 9'h020;

    typedef enum logic [2:0] {
        RK_STATUS, RK_ENABLE, RK_SET, RK_CLEAR, RK_MBOX, RK_NONE
    } reg_kind_e;

    typedef enum logic {
        ST_IDLE,
        ST_RESP
    } bus_state_e;
endpackage

// File: rtl/ipi_decode.sv
module ipi_decode
    import ipi_regfile_pkg::*;
#(
    parameter int NUM_MBOX   = 4,
    parameter int MBOX_BYTES = 8,
    localparam int WIN_BYTES = NUM_MBOX * MBOX_BYTES,
    localparam int WIN_W     = $clog2(WIN_BYTES)
) (
    input  logic [OFF_W-1:0] off,
    input  logic [LEN_W-1:0] len,
    input  logic             wr,
    output reg_kind_e        kind,
    output logic             len_ok,
    output logic             misalign,
    output logic             err,
    output logic [WIN_W-1:0] win_off
);
    localparam logic [OFF_W:0] WIN_LIM = (OFF_W+1)'(OFF_MBOX) + (OFF_W+1)'(WIN_BYTES);

    logic [OFF_W:0]   span_end;
    logic [OFF_W-1:0] len_mask;

    always_comb begin
        len_ok   = (len == 4'd1) || (len == 4'd2) || (len == 4'd4) || (len == 4'd8);
        len_mask = OFF_W'(len) - OFF_W'(1);
        misalign = len_ok && ((off & len_mask) != '0);
        span_end = {1'b0, off} + (OFF_W+1)'(len);
        win_off  = WIN_W'(off - OFF_MBOX);

        if (off == OFF_STATUS)                                   kind = RK_STATUS;
        else if (off == OFF_ENABLE)                              kind = RK_ENABLE;
        else if (off == OFF_SET)                                 kind = RK_SET;
        else if (off == OFF_CLEAR)                               kind = RK_CLEAR;
        else if (off >= OFF_MBOX && {1'b0, off} < WIN_LIM)       kind = RK_MBOX;
        else                                                     kind = RK_NONE;

        err = (kind == RK_NONE)
            || (kind == RK_STATUS && wr)
            || (kind == RK_MBOX && span_end > WIN_LIM);
    end
endmodule

// File: rtl/ipi_mailbox.sv
module ipi_mailbox
    import ipi_regfile_pkg::*;
#(
    parameter int NUM_MBOX   = 4,
    parameter int MBOX_BYTES = 8,
    parameter int RWORD_W    = 32,
    localparam int WIN_BYTES  = NUM_MBOX * MBOX_BYTES,
    localparam int WIN_W      = $clog2(WIN_BYTES),
    localparam int WORD_BYTES = RWORD_W / 8,
    localparam int NUM_WORDS  = WIN_BYTES / WORD_BYTES,
    localparam int IDX_W      = $clog2(NUM_WORDS),
    localparam int SEL_W      = $clog2(DATA_W / 8)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_we,
    input  logic [WIN_W-1:0]   bus_off,
    input  logic [LEN_W-1:0]   bus_len,
    input  logic [DATA_W-1:0]  bus_wdata,
    input  logic               rmt_we,
    input  logic [IDX_W-1:0]   rmt_idx,
    input  logic [RWORD_W-1:0] rmt_wdata,
    output logic [DATA_W-1:0]  rd_data
);
    logic [7:0]           mem_q   [WIN_BYTES];
    logic [7:0]           nxt     [WIN_BYTES];
    logic [WIN_BYTES-1:0] byte_we;

    for (genvar b = 0; b < WIN_BYTES; b++) begin : g_byte
        logic [WIN_W:0]   rel;
        logic             bus_hit;
        logic             rmt_hit;
        logic [SEL_W-1:0] lane;
        assign rel        = (WIN_W+1)'(b) - {1'b0, bus_off};
        assign lane       = rel[SEL_W-1:0];
        assign bus_hit    = bus_we && ((WIN_W+1)'(b) >= {1'b0, bus_off})
                          && (rel < (WIN_W+1)'(bus_len));
        assign rmt_hit    = rmt_we && (rmt_idx == IDX_W'(b / WORD_BYTES));
        assign byte_we[b] = bus_hit || rmt_hit;
        assign nxt[b]     = rmt_hit ? rmt_wdata[(b % WORD_BYTES)*8 +: 8]
                                    : bus_wdata[{lane, 3'b000} +: 8];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        for (int b = 0; b < WIN_BYTES; b++) begin
            if (!rst_n)          mem_q[b] <= '0;
            else if (byte_we[b]) mem_q[b] <= nxt[b];
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < DATA_W / 8; i++) begin
            logic [WIN_W:0] idx;
            idx = {1'b0, bus_off} + (WIN_W+1)'(i);
            if ((LEN_W+1)'(i) < {1'b0, bus_len} && idx < (WIN_W+1)'(WIN_BYTES))
                rd_data[i*8 +: 8] = mem_q[idx[WIN_W-1:0]];
        end
    end
endmodule

// File: rtl/ipi_status.sv
module ipi_status #(
    parameter int STAT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_we,
    input  logic              clr_we,
    input  logic              en_we,
    input  logic [STAT_W-1:0] wdata,
    input  logic              rset_we,
    input  logic [STAT_W-1:0] rset_vec,
    output logic [STAT_W-1:0] status_q,
    output logic [STAT_W-1:0] enable_q,
    output logic              irq_q
);
    logic [STAT_W-1:0] set_bits;
    logic [STAT_W-1:0] clr_bits;
    logic [STAT_W-1:0] status_d;
    logic              raise;
    logic              lower;

    always_comb begin
        set_bits = (set_we ? wdata : '0) | (rset_we ? rset_vec : '0);
        clr_bits = clr_we ? wdata : '0;
        status_d = (status_q & ~clr_bits) | set_bits;
        raise    = (status_q == '0) && (set_bits != '0);
        lower    = clr_we && (status_d == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
            enable_q <= '0;
            irq_q    <= 1'b0;
        end else begin
            status_q <= status_d;
            if (en_we) enable_q <= wdata;
            if (raise)      irq_q <= 1'b1;
            else if (lower) irq_q <= 1'b0;
        end
    end
endmodule

// File: rtl/ipi_regfile.sv
module ipi_regfile
    import ipi_regfile_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int NUM_MBOX   = 4,
    parameter int MBOX_BYTES = 8,
    localparam int RWORD_W   = 32,
    localparam int WIN_BYTES = NUM_MBOX * MBOX_BYTES,
    localparam int WIN_W     = $clog2(WIN_BYTES),
    localparam int IDX_W     = $clog2(WIN_BYTES / (RWORD_W / 8))
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [LEN_W-1:0]    req_len,
    input  logic [DATA_W-1:0]   req_wdata,
    output logic                rsp_valid,
    output logic [DATA_W-1:0]   rsp_rdata,
    output logic                rsp_err,
    output logic                rsp_misalign,
    input  logic                rmt_set_valid,
    input  logic [STATUS_W-1:0] rmt_set_vec,
    input  logic                rmt_mail_valid,
    input  logic [IDX_W-1:0]    rmt_mail_idx,
    input  logic [RWORD_W-1:0]  rmt_mail_data,
    output logic                irq
);
    bus_state_e          state_q, state_d;
    reg_kind_e           kind;
    logic                len_ok, misalign, dec_err, accept, wr_ok;
    logic [WIN_W-1:0]    win_off;
    logic [OFF_W-1:0]    off;
    logic [STATUS_W-1:0] status_val, enable_val;
    logic [DATA_W-1:0]   mb_rd, rd_mux;
    logic                irq_q;
    logic [DATA_W-1:0]   rsp_rdata_q;
    logic                rsp_err_q, rsp_mis_q;

    assign off    = req_addr[OFF_W-1:0];
    assign accept = req_valid && req_ready;
    assign wr_ok  = accept && req_write && !dec_err;

    ipi_decode #(.NUM_MBOX(NUM_MBOX), .MBOX_BYTES(MBOX_BYTES)) u_dec (
        .off(off), .len(req_len), .wr(req_write), .kind(kind), .len_ok(len_ok),
        .misalign(misalign), .err(dec_err), .win_off(win_off)
    );

    ipi_status #(.STAT_W(STATUS_W)) u_stat (
        .clk(clk), .rst_n(rst_n),
        .set_we(wr_ok && kind == RK_SET), .clr_we(wr_ok && kind == RK_CLEAR),
        .en_we(wr_ok && kind == RK_ENABLE), .wdata(req_wdata[STATUS_W-1:0]),
        .rset_we(rmt_set_valid), .rset_vec(rmt_set_vec),
        .status_q(status_val), .enable_q(enable_val), .irq_q(irq_q)
    );

    ipi_mailbox #(.NUM_MBOX(NUM_MBOX), .MBOX_BYTES(MBOX_BYTES), .RWORD_W(RWORD_W)) u_mbox (
        .clk(clk), .rst_n(rst_n),
        .bus_we(wr_ok && kind == RK_MBOX && len_ok), .bus_off(win_off),
        .bus_len(req_len), .bus_wdata(req_wdata),
        .rmt_we(rmt_mail_valid), .rmt_idx(rmt_mail_idx), .rmt_wdata(rmt_mail_data),
        .rd_data(mb_rd)
    );

    always_comb begin
        rd_mux = '0;
        if (!req_write && !dec_err) begin
            unique case (kind)
                RK_STATUS: rd_mux = DATA_W'(status_val);
                RK_ENABLE: rd_mux = DATA_W'(enable_val);
                RK_MBOX:   rd_mux = len_ok ? mb_rd : '0;
                default:   rd_mux = '0;
            endcase
        end
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = accept ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_rdata_q <= '0;
            rsp_err_q   <= 1'b0;
            rsp_mis_q   <= 1'b0;
        end else if (accept) begin
            rsp_rdata_q <= rd_mux;
            rsp_err_q   <= dec_err;
            rsp_mis_q   <= misalign;
        end
    end

    always_comb begin
        req_ready    = (state_q == ST_IDLE);
        rsp_valid    = (state_q == ST_RESP);
        rsp_rdata    = rsp_rdata_q;
        rsp_err      = rsp_err_q;
        rsp_misalign = rsp_mis_q;
        irq          = irq_q;
    end
endmodule

// File: rtl/ipi_regfile_chk.sv
module ipi_regfile_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic        req_write,
    input logic [8:0]  req_off,
    input logic [31:0] req_wdata32,
    input logic        rmt_set_valid,
    input logic        rsp_valid,
    input logic        rsp_err,
    input logic [63:0] rsp_rdata,
    input logic [31:0] status_val,
    input logic        irq
);
    a_r3_irq_tracks_status: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (status_val != 32'd0));

    a_r2_set_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_write && req_off == 9'h008 && req_wdata32 != 32'd0)
        |=> irq);

    a_r4_status_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_write && req_off == 9'h000 && !rmt_set_valid)
        |=> $stable(status_val));

    a_r12_rsp_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (rsp_valid && !req_ready));

    a_r12_rsp_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    a_r7_err_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> (rsp_rdata == 64'd0));
endmodule

bind ipi_regfile ipi_regfile_chk u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_off(req_addr[8:0]), .req_wdata32(req_wdata[31:0]),
    .rmt_set_valid(rmt_set_valid), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
    .rsp_rdata(rsp_rdata), .status_val(status_val), .irq(irq)
);

// File: tb/test_ipi_regfile.sv
`timescale 1ns/1ps
module test_ipi_regfile;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [3:0]  req_len = '0;
    logic [63:0] req_wdata = '0;
    logic        req_ready, rsp_valid, rsp_err, rsp_misalign, irq;
    logic [63:0] rsp_rdata;
    logic        rmt_set_valid = 1'b0, rmt_mail_valid = 1'b0;
    logic [31:0] rmt_set_vec = '0, rmt_mail_data = '0;
    logic [2:0]  rmt_mail_idx = '0;

    int checks = 0, fails = 0;
    bit run = 0;

    logic [7:0]  m_mb [32];
    logic [31:0] m_stat, m_en;
    logic        m_irq;
    logic [63:0] e_rd;
    logic        e_err, e_mis;
    logic [63:0] got;

    always #10 clk = ~clk;

    ipi_regfile i_ipi_regfile (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
        .rsp_misalign(rsp_misalign), .rmt_set_valid(rmt_set_valid), .rmt_set_vec(rmt_set_vec),
        .rmt_mail_valid(rmt_mail_valid), .rmt_mail_idx(rmt_mail_idx),
        .rmt_mail_data(rmt_mail_data), .irq(irq)
    );

    task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Behavioural reference: applied once per clock edge, old state first.
    task automatic model(bit bv, bit wr, int addr, int len, logic [63:0] wd,
                         bit rsv, logic [31:0] rvec, bit rmv, int ridx, logic [31:0] rmd);
        int off = addr & 'h1FF;
        bit lenok = (len == 1) || (len == 2) || (len == 4) || (len == 8);
        logic [31:0] setv = 0, clrv = 0, old = m_stat;
        bit clr = 0;
        e_rd = 0; e_err = 0; e_mis = 0;
        if (bv) begin
            if (lenok && (off % len) != 0) e_mis = 1;
            if (off == 'h000) begin
                if (wr) e_err = 1; else e_rd = {32'd0, m_stat};
            end else if (off == 'h004) begin
                if (wr) m_en = wd[31:0]; else e_rd = {32'd0, m_en};
            end else if (off == 'h008) begin
                if (wr) setv = wd[31:0];
            end else if (off == 'h00C) begin
                if (wr) begin clrv = wd[31:0]; clr = 1; end
            end else if (off >= 'h20 && off < 'h40) begin
                if (off + len > 'h40) e_err = 1;
                else if (lenok) begin
                    for (int i = 0; i < len; i++) begin
                        if (wr) m_mb[off - 'h20 + i] = wd[8*i +: 8];
                        else    e_rd[8*i +: 8] = m_mb[off - 'h20 + i];
                    end
                end
            end else e_err = 1;
        end
        if (rsv) setv = setv | rvec;
        m_stat = (old & ~clrv) | setv;
        if (old == 0 && setv != 0) m_irq = 1;
        else if (clr && m_stat == 0) m_irq = 0;
        if (rmv) for (int i = 0; i < 4; i++) m_mb[4*ridx + i] = rmd[8*i +: 8];
    endtask

    task automatic step(bit bv, bit wr, int addr, int len, logic [63:0] wd,
                        bit rsv, logic [31:0] rvec, bit rmv, int ridx, logic [31:0] rmd,
                        string tag);
        req_valid = bv; req_write = wr; req_addr = 12'(addr); req_len = 4'(len);
        req_wdata = wd; rmt_set_valid = rsv; rmt_set_vec = rvec;
        rmt_mail_valid = rmv; rmt_mail_idx = 3'(ridx); rmt_mail_data = rmd;
        @(posedge clk);
        model(bv, wr, addr, len, wd, rsv, rvec, rmv, ridx, rmd);
        @(negedge clk);
        req_valid = 0; rmt_set_valid = 0; rmt_mail_valid = 0;
        if (bv) begin
            got = rsp_rdata;
            chk(rsp_valid === 1'b1 && req_ready === 1'b0, {"R12 response cycle ", tag},
                {62'd0, rsp_valid, req_ready}, 64'd2);
            chk(rsp_rdata === e_rd, {tag, " rdata"}, rsp_rdata, e_rd);
            chk(rsp_err === e_err, {tag, " err"}, 64'(rsp_err), 64'(e_err));
            chk(rsp_misalign === e_mis, {tag, " misalign"}, 64'(rsp_misalign), 64'(e_mis));
            @(negedge clk);
            chk(rsp_valid === 1'b0 && req_ready === 1'b1, "R12 back to idle",
                {62'd0, rsp_valid, req_ready}, 64'd1);
        end
    endtask

    task automatic acc(bit wr, int addr, int len, logic [63:0] wd, string tag);
        step(1, wr, addr, len, wd, 0, 0, 0, 0, 0, tag);
    endtask

    always @(negedge clk)
        if (run) chk(irq === m_irq, "R3 irq vs model", 64'(irq), 64'(m_irq));

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        m_stat = 0; m_en = 0; m_irq = 0;
        for (int i = 0; i < 32; i++) m_mb[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        run = 1;
        chk(irq === 0 && req_ready === 1 && rsp_valid === 0, "R1 reset outputs",
            {61'd0, irq, req_ready, rsp_valid}, 64'd2);
        acc(0, 'h000, 4, 0, "R1 status"); chk(got === 0, "R1 status zero", got, 0);
        acc(0, 'h004, 4, 0, "R1 enable"); chk(got === 0, "R1 enable zero", got, 0);
        acc(0, 'h020, 8, 0, "R1 mbox0");
        acc(0, 'h038, 8, 0, "R1 mbox3");

        acc(1, 'h008, 4, 0, "R2 set zero");
        chk(irq === 0, "R2 zero set keeps irq low", 64'(irq), 0);
        acc(1, 'h008, 4, 64'h5, "R2 set");
        chk(irq === 1, "R2 irq raised", 64'(irq), 1);
        acc(1, 'h008, 4, 64'h100, "R2 set more");
        acc(0, 'h000, 4, 0, "R2 status read"); chk(got === 64'h105, "R2 status OR", got, 64'h105);

        acc(1, 'h00C, 4, 64'h4, "R3 partial clear");
        chk(irq === 1, "R3 irq held", 64'(irq), 1);
        acc(0, 'h000, 4, 0, "R3 status"); chk(got === 64'h101, "R3 status", got, 64'h101);
        acc(1, 'h00C, 4, 64'hFFFF_FFFF, "R3 full clear");
        chk(irq === 0, "R3 irq lowered", 64'(irq), 0);

        acc(1, 'h008, 4, 64'h30, "R4 set");
        acc(0, 'h008, 4, 0, "R4 read set"); chk(got === 0, "R4 set reads 0", got, 0);
        acc(0, 'h00C, 4, 0, "R4 read clear");
        acc(1, 'h000, 4, 64'hFFFF, "R4 status write");
        acc(0, 'h000, 4, 0, "R4 status kept"); chk(got === 64'h30, "R4 status", got, 64'h30);

        acc(1, 'h004, 4, 64'hFFFF_FFFF_A5A5_0001, "R5 enable write");
        acc(0, 'h004, 4, 0, "R5 enable read"); chk(got === 64'hA5A5_0001, "R5 enable", got, 64'hA5A5_0001);
        chk(irq === 1, "R5 irq unchanged", 64'(irq), 1);
        acc(1, 'h00C, 4, 64'h30, "R5 tidy");

        acc(1, 'h020, 8, 64'h1122_3344_5566_7788, "R6 write8");
        acc(0, 'h023, 1, 0, "R6 read1"); chk(got === 64'h55, "R6 byte", got, 64'h55);
        acc(0, 'h026, 2, 0, "R6 read2"); chk(got === 64'h1122, "R6 half", got, 64'h1122);
        acc(0, 'h024, 4, 0, "R6 read4"); chk(got === 64'h1122_3344, "R6 word", got, 64'h1122_3344);
        acc(1, 'h02F, 1, 64'hEE, "R6 write1");
        acc(0, 'h028, 8, 0, "R6 read8"); chk(got === 64'hEE00_0000_0000_0000, "R6 byte lane", got, 64'hEE00_0000_0000_0000);
        acc(1, 'h034, 4, 64'hDEAD_0000_CAFE_BABE, "R6 write4");
        acc(0, 'h030, 8, 0, "R6 read8 hi");

        acc(1, 'h03C, 8, 64'hFFFF_FFFF_FFFF_FFFF, "R7 overrun write");
        acc(0, 'h038, 8, 0, "R7 untouched");
        acc(0, 'h03E, 4, 0, "R7 overrun read");
        acc(0, 'h010, 4, 0, "R7 unknown");
        acc(1, 'h040, 4, 64'h1, "R7 past window");
        acc(0, 'h1FF, 1, 0, "R7 top");
        acc(1, 'h001, 4, 64'h1, "R7 odd offset");

        acc(1, 'h020, 3, 64'hFFFF_FFFF, "R8 len3 write");
        acc(1, 'h020, 0, 64'hFFFF_FFFF, "R8 len0 write");
        acc(0, 'h020, 3, 0, "R8 len3 read"); chk(got === 0, "R8 zero", got, 0);
        acc(0, 'h020, 8, 0, "R8 kept"); chk(got === 64'h1122_3344_5566_7788, "R8 kept", got, 64'h1122_3344_5566_7788);

        acc(1, 'h021, 2, 64'hBEEF, "R9 misaligned write");
        acc(0, 'h020, 8, 0, "R9 result"); chk(got === 64'h1122_3344_55BE_EF88, "R9 data", got, 64'h1122_3344_55BE_EF88);
        acc(0, 'h026, 4, 0, "R9 misaligned read");
        acc(0, 'h00C, 8, 0, "R9 reg misalign");

        step(0, 0, 0, 0, 0, 1, 32'h8000_0000, 0, 0, 0, "R10 remote alone");
        chk(irq === 1, "R10 remote raise", 64'(irq), 1);
        acc(1, 'h00C, 4, 64'h8000_0000, "R10 clear");
        step(1, 1, 'h008, 4, 64'h1, 1, 32'h10, 0, 0, 0, "R10 merged set");
        acc(0, 'h000, 4, 0, "R10 status"); chk(got === 64'h11, "R10 merge", got, 64'h11);
        step(1, 1, 'h00C, 4, 64'h11, 1, 32'h200, 0, 0, 0, "R10 clear plus remote");
        acc(0, 'h000, 4, 0, "R10 status2"); chk(got === 64'h200, "R10 order", got, 64'h200);
        chk(irq === 1, "R10 irq held", 64'(irq), 1);
        acc(1, 'h00C, 4, 64'h200, "R10 final clear");

        step(0, 0, 0, 0, 0, 0, 0, 1, 5, 32'hCAFE_F00D, "R11 remote word");
        acc(0, 'h034, 4, 0, "R11 read"); chk(got === 64'hCAFE_F00D, "R11 word", got, 64'hCAFE_F00D);
        step(1, 1, 'h030, 8, 64'h0102_0304_0506_0708, 0, 0, 1, 5, 32'hDEAD_BEEF, "R11 overlap");
        acc(0, 'h030, 8, 0, "R11 overlap read"); chk(got === 64'hDEAD_BEEF_0506_0708, "R11 remote wins", got, 64'hDEAD_BEEF_0506_0708);

        acc(1, 'hE08, 4, 64'h4, "R12 high addr bits");
        acc(0, 'h600, 4, 0, "R12 status alias"); chk(got === 64'h4, "R12 alias", got, 64'h4);
        acc(1, 'hA0C, 4, 64'h4, "R12 clear alias");

        run = 0;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule